// File: doc/BRIEF.md
# Single-Cycle Word-Addressed RISC Core

This block is a small processor that executes one 32-bit instruction per clock from a memory shared by code and data. In each cycle it presents the program counter on the memory address, takes the returned word as the current instruction, and computes the next counter value. The next value is the current counter plus four, or a jump destination. In the same cycle it selects operands from a 32-entry register file, runs them through the arithmetic/logic path and commits the result at the closing clock edge.

Three instruction layouts are decoded. The register form has a 6-bit opcode in bits 31:26, a first source in 25:21, a second source in 20:16, a destination in 15:11, a shift count in 10:6 and a function selector in 5:0. The immediate form keeps the opcode and the two register fields and puts a 16-bit constant in 15:0. The jump form puts a 26-bit word index below the opcode. A debug port reads any register and the counter without disturbing execution. The memory read is combinational within the cycle. The write side of the memory port exists but is never driven active, because the core has no store instructions.

Top module: `rcore_top`

## Requirements
- R1: An active-low asynchronous reset sets the program counter to 0x00000000 and every register to zero.
- R2: The core presents the program counter on `mem_addr`. For any instruction other than a jump, the counter grows by exactly 4 at the end of its cycle.
- R3: Register 0 always reads as zero, including after instructions that name it as their destination.
- R4: With opcode 0x00, function codes 0x20/0x21 (add) and 0x22/0x23 (subtract) write rs+rt or rs−rt, modulo 2^32, into rd.
- R5: With opcode 0x00, function codes 0x24 (and), 0x25 (or), 0x26 (xor) and 0x27 (nor) write the bitwise result of rs and rt into rd.
- R6: With opcode 0x00, function 0x2A writes 1 into rd when rs < rt as signed numbers and 0 otherwise. Function 0x2B does the same with an unsigned comparison.
- R7: With opcode 0x00, functions 0x00 (left), 0x02 (logical right) and 0x03 (arithmetic right) shift rt by the shift-count field and write rd.
- R8: With opcode 0x00, functions 0x04, 0x06 and 0x07 shift rt in the same three ways, by the low 5 bits of register rs.
- R9: Opcodes 0x08/0x09 (add), 0x0A (signed less-than) and 0x0B (unsigned less-than) use the sign-extended 16-bit constant and write rt.
- R10: Opcodes 0x0C (and), 0x0D (or) and 0x0E (xor) use the zero-extended constant. Opcode 0x0F writes the constant shifted left by 16. All four write rt.
- R11: Opcode 0x02 sets the counter to {bits 31:28 of counter+4, the 26-bit field, 2'b00}. Execution continues at that address on the next cycle.
- R12: Any other opcode, and any function code with opcode 0x00 not listed above, leaves every register unchanged and only advances the counter by 4.
- R13: Each instruction reads the values written by the instruction immediately before it.
- R14: `mem_we` stays 0 and `mem_wdata` stays zero at all times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| mem_addr | output | 32 | Byte address of the instruction fetch (the program counter) |
| mem_rdata | input | 32 | Word returned by memory for `mem_addr` in the same cycle |
| mem_wdata | output | 32 | Write data toward memory, always zero |
| mem_we | output | 1 | Memory write enable, never asserted |
| dbg_sel | input | 5 | Register index for the debug read |
| dbg_data | output | 32 | Contents of the register chosen by `dbg_sel` |
| dbg_pc | output | 32 | Current program counter |

## Verification
The program pairs signed and unsigned variants on operands whose sign bit is set. A core that mixed up the two comparisons, or shifted right with zero fill where sign fill belongs, writes a visibly different value. Sign and zero extension of the constant are tested on all-ones fields, where a wrong extension flips the upper half. Writes that name register 0, unknown opcodes and unknown function codes are each followed by a register read-back, which catches a core that lets a stray write through. The final jumps cross the 0x10000000 boundary, so a core that builds the target from the current counter instead of counter+4 lands on the wrong address.

// File: rtl/rcore_pkg.sv
package rcore_pkg;

  localparam int unsigned WORD_W   = 32;
  localparam int unsigned REG_AW   = 5;
  localparam int unsigned SH_W     = 5;
  localparam int unsigned IMM_W    = 16;
  localparam int unsigned TGT_W    = 26;
  localparam int unsigned STEP_B   = 4;

  // opcode field values
  localparam logic [5:0] OPC_REG   = 6'h00;
  localparam logic [5:0] OPC_JMP   = 6'h02;
  localparam logic [5:0] OPC_ADDI  = 6'h08;
  localparam logic [5:0] OPC_ADDIU = 6'h09;
  localparam logic [5:0] OPC_SLTI  = 6'h0A;
  localparam logic [5:0] OPC_SLTIU = 6'h0B;
  localparam logic [5:0] OPC_ANDI  = 6'h0C;
  localparam logic [5:0] OPC_ORI   = 6'h0D;
  localparam logic [5:0] OPC_XORI  = 6'h0E;
  localparam logic [5:0] OPC_LUI   = 6'h0F;

  // function field values for the register form
  localparam logic [5:0] FN_SLL  = 6'h00;
  localparam logic [5:0] FN_SRL  = 6'h02;
  localparam logic [5:0] FN_SRA  = 6'h03;
  localparam logic [5:0] FN_SLLV = 6'h04;
  localparam logic [5:0] FN_SRLV = 6'h06;
  localparam logic [5:0] FN_SRAV = 6'h07;
  localparam logic [5:0] FN_ADD  = 6'h20;
  localparam logic [5:0] FN_ADDU = 6'h21;
  localparam logic [5:0] FN_SUB  = 6'h22;
  localparam logic [5:0] FN_SUBU = 6'h23;
  localparam logic [5:0] FN_AND  = 6'h24;
  localparam logic [5:0] FN_OR   = 6'h25;
  localparam logic [5:0] FN_XOR  = 6'h26;
  localparam logic [5:0] FN_NOR  = 6'h27;
  localparam logic [5:0] FN_SLT  = 6'h2A;
  localparam logic [5:0] FN_SLTU = 6'h2B;

  typedef enum logic [3:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR, ALU_NOR,
    ALU_SLT, ALU_SLTU, ALU_SLL, ALU_SRL, ALU_SRA, ALU_LUI
  } alu_op_e;

  typedef struct packed {
    alu_op_e             op;
    logic                use_imm;
    logic                var_shift;
    logic                wr_en;
    logic [REG_AW-1:0]   wr_addr;
    logic                is_jump;
    logic                illegal;
    logic [WORD_W-1:0]   imm;
  } ctrl_t;

  function automatic logic [WORD_W-1:0] sext_imm(input logic [IMM_W-1:0] v);
    return {{(WORD_W-IMM_W){v[IMM_W-1]}}, v};
  endfunction

  function automatic logic [WORD_W-1:0] zext_imm(input logic [IMM_W-1:0] v);
    return {{(WORD_W-IMM_W){1'b0}}, v};
  endfunction

  function automatic logic [WORD_W-1:0] alu_eval(input alu_op_e op,
                                                 input logic [WORD_W-1:0] a,
                                                 input logic [WORD_W-1:0] b,
                                                 input logic [SH_W-1:0] sh);
    case (op)
      ALU_ADD:  return a + b;
      ALU_SUB:  return a - b;
      ALU_AND:  return a & b;
      ALU_OR:   return a | b;
      ALU_XOR:  return a ^ b;
      ALU_NOR:  return ~(a | b);
      ALU_SLT:  return {{(WORD_W-1){1'b0}}, ($signed(a) < $signed(b))};
      ALU_SLTU: return {{(WORD_W-1){1'b0}}, (a < b)};
      ALU_SLL:  return b << sh;
      ALU_SRL:  return b >> sh;
      ALU_SRA:  return $unsigned($signed(b) >>> sh);
      ALU_LUI:  return {b[IMM_W-1:0], {(WORD_W-IMM_W){1'b0}}};
      default:  return '0;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] jump_dest(input logic [WORD_W-1:0] pc_next_seq,
                                                  input logic [TGT_W-1:0] idx);
    return {pc_next_seq[WORD_W-1:TGT_W+2], idx, 2'b00};
  endfunction

endpackage

// File: rtl/rcore_decode.sv
module rcore_decode
  import rcore_pkg::*;
(
  input  logic [WORD_W-1:0] instr,
  output ctrl_t             ctrl
);

  logic [5:0]        opc;
  logic [5:0]        fn;
  logic [REG_AW-1:0] f_rt;
  logic [REG_AW-1:0] f_rd;
  logic [IMM_W-1:0]  f_imm;

  assign opc   = instr[31:26];
  assign fn    = instr[5:0];
  assign f_rt  = instr[20:16];
  assign f_rd  = instr[15:11];
  assign f_imm = instr[15:0];

  always_comb begin
    ctrl         = '0;
    ctrl.op      = ALU_ADD;
    ctrl.imm     = sext_imm(f_imm);
    ctrl.wr_addr = f_rt;
    case (opc)
      OPC_REG: begin
        ctrl.wr_en   = 1'b1;
        ctrl.wr_addr = f_rd;
        case (fn)
          FN_ADD, FN_ADDU: ctrl.op = ALU_ADD;
          FN_SUB, FN_SUBU: ctrl.op = ALU_SUB;
          FN_AND:  ctrl.op = ALU_AND;
          FN_OR:   ctrl.op = ALU_OR;
          FN_XOR:  ctrl.op = ALU_XOR;
          FN_NOR:  ctrl.op = ALU_NOR;
          FN_SLT:  ctrl.op = ALU_SLT;
          FN_SLTU: ctrl.op = ALU_SLTU;
          FN_SLL:  ctrl.op = ALU_SLL;
          FN_SRL:  ctrl.op = ALU_SRL;
          FN_SRA:  ctrl.op = ALU_SRA;
          FN_SLLV: begin ctrl.op = ALU_SLL; ctrl.var_shift = 1'b1; end
          FN_SRLV: begin ctrl.op = ALU_SRL; ctrl.var_shift = 1'b1; end
          FN_SRAV: begin ctrl.op = ALU_SRA; ctrl.var_shift = 1'b1; end
          default: begin ctrl.wr_en = 1'b0; ctrl.illegal = 1'b1; end
        endcase
      end
      OPC_JMP: ctrl.is_jump = 1'b1;
      OPC_ADDI, OPC_ADDIU: begin
        ctrl.op = ALU_ADD;  ctrl.use_imm = 1'b1; ctrl.wr_en = 1'b1;
      end
      OPC_SLTI: begin
        ctrl.op = ALU_SLT;  ctrl.use_imm = 1'b1; ctrl.wr_en = 1'b1;
      end
      OPC_SLTIU: begin
        ctrl.op = ALU_SLTU; ctrl.use_imm = 1'b1; ctrl.wr_en = 1'b1;
      end
      OPC_ANDI: begin
        ctrl.op = ALU_AND; ctrl.use_imm = 1'b1; ctrl.wr_en = 1'b1;
        ctrl.imm = zext_imm(f_imm);
      end
      OPC_ORI: begin
        ctrl.op = ALU_OR;  ctrl.use_imm = 1'b1; ctrl.wr_en = 1'b1;
        ctrl.imm = zext_imm(f_imm);
      end
      OPC_XORI: begin
        ctrl.op = ALU_XOR; ctrl.use_imm = 1'b1; ctrl.wr_en = 1'b1;
        ctrl.imm = zext_imm(f_imm);
      end
      OPC_LUI: begin
        ctrl.op = ALU_LUI; ctrl.use_imm = 1'b1; ctrl.wr_en = 1'b1;
        ctrl.imm = zext_imm(f_imm);
      end
      default: ctrl.illegal = 1'b1;
    endcase
  end

endmodule

// File: rtl/rcore_regfile.sv
module rcore_regfile #(
  parameter int unsigned NREGS = 32,
  parameter int unsigned WIDTH = 32,
  parameter int unsigned NRD   = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      we,
  input  logic [$clog2(NREGS)-1:0]  waddr,
  input  logic [WIDTH-1:0]          wdata,
  input  logic [NRD-1:0][$clog2(NREGS)-1:0] raddr,
  output logic [NRD-1:0][WIDTH-1:0] rdata
);

  localparam int unsigned AW = $clog2(NREGS);

  logic [WIDTH-1:0] cells [NREGS];
  logic             wr_live;

  // a write naming entry zero is dropped here
  assign wr_live = we && (waddr != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) cells[i] <= '0;
    end else if (wr_live) begin
      cells[waddr] <= wdata;
    end
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rdata[g] = (raddr[g] == AW'(0)) ? '0 : cells[raddr[g]];
  end

  // R13: a committed result is present for the next instruction to read
  p_write_lands_r13: assert property (@(posedge clk) disable iff (!rst_n)
    wr_live |=> cells[$past(waddr)] == $past(wdata));

endmodule

// File: rtl/rcore_top.sv
module rcore_top
  import rcore_pkg::*;
#(
  parameter logic [31:0] RESET_PC = 32'h0000_0000,
  parameter int unsigned NUM_REGS = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic [31:0] mem_addr,
  input  logic [31:0] mem_rdata,
  output logic [31:0] mem_wdata,
  output logic        mem_we,
  input  logic [4:0]  dbg_sel,
  output logic [31:0] dbg_data,
  output logic [31:0] dbg_pc
);

  localparam int unsigned RD_PORTS = 3;
  localparam int unsigned RD_RS    = 0;
  localparam int unsigned RD_RT    = 1;
  localparam int unsigned RD_DBG   = 2;

  logic [WORD_W-1:0] pc_q, pc_plus4, pc_next;
  logic [WORD_W-1:0] instr;
  ctrl_t             ctrl;
  logic [RD_PORTS-1:0][REG_AW-1:0] rf_raddr;
  logic [RD_PORTS-1:0][WORD_W-1:0] rf_rdata;
  logic [WORD_W-1:0] opnd_a, opnd_b;
  logic [SH_W-1:0]   sh_amt;

  // named events for the assertions
  logic              jump_taken;
  logic              illegal_seen;
  logic              wb_en;
  logic [REG_AW-1:0] wb_addr;
  logic [WORD_W-1:0] wb_data;

  assign instr    = mem_rdata;
  assign mem_addr = pc_q;
  assign mem_wdata = '0;
  assign mem_we   = 1'b0;
  assign dbg_pc   = pc_q;

  rcore_decode u_dec (
    .instr (instr),
    .ctrl  (ctrl)
  );

  assign rf_raddr[RD_RS]  = instr[25:21];
  assign rf_raddr[RD_RT]  = instr[20:16];
  assign rf_raddr[RD_DBG] = dbg_sel;
  assign dbg_data         = rf_rdata[RD_DBG];

  assign opnd_a = rf_rdata[RD_RS];
  assign opnd_b = ctrl.use_imm   ? ctrl.imm : rf_rdata[RD_RT];
  assign sh_amt = ctrl.var_shift ? opnd_a[SH_W-1:0] : instr[10:6];

  assign wb_en        = ctrl.wr_en;
  assign wb_addr      = ctrl.wr_addr;
  assign wb_data      = alu_eval(ctrl.op, opnd_a, opnd_b, sh_amt);
  assign jump_taken   = ctrl.is_jump;
  assign illegal_seen = ctrl.illegal;

  rcore_regfile #(
    .NREGS (NUM_REGS),
    .WIDTH (WORD_W),
    .NRD   (RD_PORTS)
  ) u_rf (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wb_en),
    .waddr (wb_addr),
    .wdata (wb_data),
    .raddr (rf_raddr),
    .rdata (rf_rdata)
  );

  assign pc_plus4 = pc_q + WORD_W'(STEP_B);
  assign pc_next  = jump_taken ? jump_dest(pc_plus4, instr[TGT_W-1:0]) : pc_plus4;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= RESET_PC;
    else        pc_q <= pc_next;
  end

  // R2: sequential flow steps the counter by one word
  p_pc_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !jump_taken |=> pc_q == $past(pc_q) + 32'd4);

  // R11: jump destination keeps the top nibble of counter+4
  p_jump_dest_r11: assert property (@(posedge clk) disable iff (!rst_n)
    jump_taken |=> pc_q == {$past(pc_q + 32'd4) >> 28, 28'h0} + {4'h0, $past(mem_rdata[25:0]), 2'b00});

  // R3: entry zero is never seen as nonzero on the debug port
  p_zero_reg_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_sel == 5'd0) |-> (dbg_data == 32'd0));

  // R12: an instruction is at most one of jump, write or unknown
  p_single_class_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({jump_taken, wb_en, illegal_seen}));

  // R12: an unknown encoding only moves the counter on
  p_unknown_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_seen |=> pc_q == $past(pc_q) + 32'd4);

  // R6: compare results are 0 or 1
  p_cmp_bool_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_en && (ctrl.op == ALU_SLT || ctrl.op == ALU_SLTU)) |-> (wb_data[31:1] == 31'd0));

endmodule

// File: tb/rcore_top_tb_top.sv
module rcore_top_tb_top;

  localparam int MEM_AW = 6;
  localparam int MEM_WORDS = 1 << MEM_AW;
  localparam int NV = 29;

  logic        clk;
  logic        rst_n;
  logic [31:0] mem_addr, mem_rdata, mem_wdata;
  logic        mem_we;
  logic [4:0]  dbg_sel;
  logic [31:0] dbg_data, dbg_pc;

  logic [31:0] mem [MEM_WORDS];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  assign mem_rdata = mem[mem_addr[MEM_AW+1:2]];

  rcore_top dut_i (
    .clk (clk), .rst_n (rst_n),
    .mem_addr (mem_addr), .mem_rdata (mem_rdata),
    .mem_wdata (mem_wdata), .mem_we (mem_we),
    .dbg_sel (dbg_sel), .dbg_data (dbg_data), .dbg_pc (dbg_pc)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [31:0] r_ins(input logic [5:0] fn, input logic [4:0] rs,
                                        input logic [4:0] rt, input logic [4:0] rd,
                                        input logic [4:0] sh);
    return {6'h00, rs, rt, rd, sh, fn};
  endfunction

  function automatic logic [31:0] i_ins(input logic [5:0] op, input logic [4:0] rs,
                                        input logic [4:0] rt, input logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  typedef struct packed {
    logic [31:0] ins;
    logic [4:0]  dst;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam vec_t VT [NV] = '{
    '{i_ins(6'h08, 0, 1, 16'd7),     5'd1,  32'h0000_0007, 4'd9},  // R9 addi
    '{i_ins(6'h08, 0, 2, 16'hFFFD),  5'd2,  32'hFFFF_FFFD, 4'd9},  // R9 sign extension
    '{r_ins(6'h20, 1, 2, 3, 0),      5'd3,  32'h0000_0004, 4'd13}, // R13 uses prior results
    '{r_ins(6'h22, 2, 1, 4, 0),      5'd4,  32'hFFFF_FFF6, 4'd4},  // R4 sub
    '{i_ins(6'h0F, 0, 5, 16'h8000),  5'd5,  32'h8000_0000, 4'd10}, // R10 upper constant
    '{r_ins(6'h21, 5, 5, 6, 0),      5'd6,  32'h0000_0000, 4'd4},  // R4 wrap
    '{i_ins(6'h0D, 0, 7, 16'hF0F0),  5'd7,  32'h0000_F0F0, 4'd10}, // R10 ori zero ext
    '{i_ins(6'h0C, 2, 8, 16'hFFFF),  5'd8,  32'h0000_FFFD, 4'd10}, // R10 andi
    '{i_ins(6'h0E, 7, 9, 16'h00FF),  5'd9,  32'h0000_F00F, 4'd10}, // R10 xori
    '{r_ins(6'h24, 2, 7, 10, 0),     5'd10, 32'h0000_F0F0, 4'd5},  // R5 and
    '{r_ins(6'h25, 1, 7, 11, 0),     5'd11, 32'h0000_F0F7, 4'd5},  // R5 or
    '{r_ins(6'h26, 1, 2, 12, 0),     5'd12, 32'hFFFF_FFFA, 4'd5},  // R5 xor
    '{r_ins(6'h27, 1, 0, 13, 0),     5'd13, 32'hFFFF_FFF8, 4'd5},  // R5 nor
    '{r_ins(6'h2A, 2, 1, 14, 0),     5'd14, 32'h0000_0001, 4'd6},  // R6 signed
    '{r_ins(6'h2B, 2, 1, 15, 0),     5'd15, 32'h0000_0000, 4'd6},  // R6 unsigned
    '{i_ins(6'h0A, 2, 16, 16'hFFFE), 5'd16, 32'h0000_0001, 4'd9},  // R9 slti
    '{i_ins(6'h0B, 1, 17, 16'hFFFF), 5'd17, 32'h0000_0001, 4'd9},  // R9 sltiu
    '{r_ins(6'h00, 0, 1, 18, 4),     5'd18, 32'h0000_0070, 4'd7},  // R7 left
    '{r_ins(6'h02, 0, 2, 19, 28),    5'd19, 32'h0000_000F, 4'd7},  // R7 logical right
    '{r_ins(6'h03, 0, 4, 20, 1),     5'd20, 32'hFFFF_FFFB, 4'd7},  // R7 arithmetic right
    '{r_ins(6'h04, 1, 1, 21, 0),     5'd21, 32'h0000_0380, 4'd8},  // R8 left by reg
    '{r_ins(6'h06, 3, 5, 22, 0),     5'd22, 32'h0800_0000, 4'd8},  // R8 logical by reg
    '{r_ins(6'h07, 3, 5, 23, 0),     5'd23, 32'hF800_0000, 4'd8},  // R8 arithmetic by reg
    '{i_ins(6'h08, 1, 0, 16'd5),     5'd0,  32'h0000_0000, 4'd3},  // R3 imm write to r0
    '{r_ins(6'h20, 1, 1, 0, 0),      5'd0,  32'h0000_0000, 4'd3},  // R3 reg write to r0
    '{i_ins(6'h3F, 0, 1, 16'h1234),  5'd1,  32'h0000_0007, 4'd12}, // R12 unknown opcode
    '{r_ins(6'h3E, 0, 0, 1, 0),      5'd1,  32'h0000_0007, 4'd12}, // R12 unknown function
    '{i_ins(6'h09, 1, 24, 16'hFFF8), 5'd24, 32'hFFFF_FFFF, 4'd9},  // R9 addiu
    '{r_ins(6'h20, 24, 1, 25, 0),    5'd25, 32'h0000_0006, 4'd13}  // R13 back to back
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic read_reg(input logic [4:0] idx, output logic [31:0] val);
    dbg_sel = idx;
    #1;
    val = dbg_data;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
    end
  end

  initial begin
    logic [31:0] v;
    for (int k = 0; k < MEM_WORDS; k++) mem[k] = 32'h0;
    for (int k = 0; k < NV; k++) mem[k] = VT[k].ins;
    mem[29] = {6'h02, 26'd40};          // jump to byte 0xA0
    mem[40] = i_ins(6'h08, 0, 26, 16'd1);
    mem[41] = {6'h02, 26'h3FF_FFFF};    // to 0x0FFFFFFC
    mem[63] = {6'h02, 26'd5};           // crosses into 0x1xxxxxxx
    rst_n = 1'b0;
    dbg_sel = 5'd0;
    repeat (3) @(negedge clk);

    // R1 reset state
    check("R1 pc", dbg_pc, 32'h0);
    for (int r = 0; r < 32; r++) begin
      read_reg(5'(r), v);
      check("R1 reg", v, 32'h0);
    end
    rst_n = 1'b1;
    #1;
    check("R2 fetch address", mem_addr, 32'h0);

    for (int i = 0; i < NV; i++) begin
      step();
      read_reg(VT[i].dst, v);
      if (v !== VT[i].exp) $display("  vector %0d belongs to R%0d", i, VT[i].req);
      check("vector result", v, VT[i].exp);
      check("R2 pc step", dbg_pc, 32'(4 * (i + 1)));
      check("R14 no write", {31'h0, mem_we} | mem_wdata, 32'h0);
    end

    // R11 jumps
    step();
    check("R11 jump near", dbg_pc, 32'h0000_00A0);
    step();
    read_reg(5'd26, v);
    check("R11 landing executes", v, 32'h1);
    check("R2 after landing", dbg_pc, 32'h0000_00A4);
    step();
    check("R11 jump far", dbg_pc, 32'h0FFF_FFFC);
    step();
    check("R11 upper nibble from pc+4", dbg_pc, 32'h1000_0014);

    // R1 asynchronous reset mid run
    rst_n = 1'b0;
    #1;
    check("R1 async pc", dbg_pc, 32'h0);
    read_reg(5'd1, v);
    check("R1 async reg", v, 32'h0);

    done = 1;
    finish_run();
  end

endmodule